// File: doc/BRIEF.md
# Oblivious Path-Tree Block Store

This block stores a small set of fixed-size logical blocks so that the memory traffic it generates says nothing about which block is being accessed. The storage is a binary tree of buckets held on chip. There are L+1 levels and 2^L leaves, and every bucket has Z slots. Each logical block carries a leaf label. A block always sits either in a bucket on the path from the root to its labelled leaf, or in a small on-chip holding area called the stash. A leaf map holds the current label of every block address.

Every request, whether a read or a write, follows the same fixed sequence:

1. Look up the block's label.
2. Pull every real block on that root-to-leaf path into the stash, one level per cycle, starting at the root.
3. Serve the request from the stash, and give the block a new label from an internal 16-bit LFSR.
4. Write the same path back, one level per cycle, starting at the leaf. Each stash block goes into the deepest bucket whose subtree contains its own label. Unused slots are written as empty.

An address that has never been written is treated as holding zero. It gets a label on its first access. If a block has to enter the stash while every stash entry is occupied, that block is lost and a sticky error output is raised.

Requests arrive on a valid/ready channel carrying an operation, an address and write data. Each request produces exactly one response on a second valid/ready channel; for a write, the response carries the value the block held before the write. Only one request is in flight at a time. The request channel's ready stays low from acceptance until the response has been taken. The response channel holds its data for as long as the consumer keeps its ready low, so back-pressure on responses stalls the whole block.

Top module: `porm_ctrl`

## Requirements
- R1: During and right after reset, `req_ready` is 1, `rsp_valid` is 0 and `err` is 0.
- R2: A request is taken on a rising edge where `req_valid` and `req_ready` are both 1. From that edge until the response is consumed, `req_ready` is 0, and any values driven on the request inputs in that time have no effect on stored data.
- R3: `rsp_valid` rises exactly 2L+3 clock cycles after the accepting edge (9 cycles with L=3), for reads and writes alike.
- R4: While `rsp_valid` is 1 and `rsp_ready` is 0, both `rsp_valid` and `rsp_rdata` hold. The response is consumed on the first rising edge with `rsp_ready` at 1, and in the following cycle `rsp_valid` is 0 and `req_ready` is 1.
- R5: A read (`req_write`=0) returns in `rsp_rdata` the most recent value written to that address.
- R6: A read of an address that has never been written returns 0.
- R7: A write (`req_write`=1) stores `req_wdata` and returns in `rsp_rdata` the value the address held before the write, which is 0 if the address was never written.
- R8: When a block has to be placed into a stash whose entries are all occupied, `err` goes to 1 and stays at 1 until reset. For example, with L=1, Z=1 and a one-entry stash, writing five distinct addresses must raise it.
- R9: When the stash has at least as many entries as there are logical blocks (the default of 16 versus 8), `err` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | $clog2(NBLK) | Logical block address |
| req_wdata | input | DW | Data for a write |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | DW | Read data, or previous contents for a write |
| err | output | 1 | Sticky stash-overflow flag |

## Verification
The only timed result is the response. It is due 2L+3 cycles after the accepting edge: one cycle per level to fetch the path, one cycle to serve, and one cycle per level to write the path back. The bench counts edges from acceptance and samples on the falling edge. At every falling edge before the due cycle it expects `rsp_valid` and `req_ready` low; at the due edge it expects the response with the value its behavioural store predicts. It then holds back `rsp_ready` for a varying number of cycles and checks that the response stays unchanged each cycle. The error flag is checked every cycle on the default instance, and against a capacity argument on a second, deliberately tiny instance.

// File: rtl/porm_pkg.sv
package porm_pkg;

  // Controller phases, shared by the sequencer and the stash datapath
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_SERVE,
    PH_EVICT,
    PH_RESP
  } phase_e;

  // Feedback mask of a maximal-length 16-bit Galois LFSR
  localparam logic [15:0] LFSR_TAPS = 16'hB400;

endpackage

// File: rtl/porm_lfsr.sv
module porm_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1,
  parameter int          OW   = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [OW-1:0] rnd
);

  logic [15:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SEED;
    end else if (step) begin
      st <= st[0] ? ((st >> 1) ^ porm_pkg::LFSR_TAPS) : (st >> 1);
    end
  end

  assign rnd = st[OW-1:0];

  // Leaf labels stay random only while the register never locks at zero (R5)
  p_lfsr_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st != 16'h0000);

endmodule

// File: rtl/porm_posmap.sv
module porm_posmap #(
  parameter int NBLK = 8,
  parameter int AW   = 3,
  parameter int L    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_hit,
  output logic [L-1:0]  rd_leaf,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [L-1:0]  wr_leaf
);

  logic [L-1:0]    leaf_q [NBLK];
  logic [NBLK-1:0] known_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      known_q <= '0;
      for (int i = 0; i < NBLK; i++) leaf_q[i] <= '0;
    end else if (wr_en) begin
      known_q[wr_addr] <= 1'b1;
      leaf_q[wr_addr]  <= wr_leaf;
    end
  end

  assign rd_hit  = known_q[rd_addr];
  assign rd_leaf = leaf_q[rd_addr];

endmodule

// File: rtl/porm_stash.sv
module porm_stash #(
  parameter int L       = 3,
  parameter int AW      = 3,
  parameter int DW      = 16,
  parameter int Z       = 4,
  parameter int STASH_N = 16,
  parameter int LVW     = 2,
  parameter int SLW     = 1 + AW + L + DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  porm_pkg::phase_e        phase,
  input  logic [LVW-1:0]          lvl,
  input  logic [L-1:0]            path_leaf,
  input  logic [Z-1:0][SLW-1:0]   fetch_bkt,
  output logic [Z-1:0][SLW-1:0]   evict_bkt,
  input  logic [AW-1:0]           srv_addr,
  input  logic                    srv_write,
  input  logic [DW-1:0]           srv_wdata,
  input  logic [L-1:0]            srv_leaf,
  output logic [DW-1:0]           srv_rdata,
  output logic                    ovf
);
  import porm_pkg::*;

  // Slot layout: {valid, address, leaf, data}
  localparam int VB = SLW - 1;
  localparam int AH = DW + L + AW - 1;
  localparam int AL = DW + L;
  localparam int LH = DW + L - 1;
  localparam int LL = DW;

  logic [SLW-1:0]     ent_q [STASH_N];
  logic [SLW-1:0]     ent_d [STASH_N];
  logic [DW-1:0]      rdata_q, rdata_d;
  logic [STASH_N-1:0] hit_vec;
  logic               placed, hit;

  // True when leaf a lies in the subtree of the bucket at this depth on b's path
  function automatic logic same_branch(input logic [L-1:0] a, input logic [L-1:0] b,
                                       input int depth);
    return (a >> (L - depth)) == (b >> (L - depth));
  endfunction

  always_comb begin
    for (int i = 0; i < STASH_N; i++)
      hit_vec[i] = ent_q[i][VB] && (ent_q[i][AH:AL] == srv_addr);
  end

  always_comb begin
    ent_d     = ent_q;
    rdata_d   = rdata_q;
    evict_bkt = '0;
    ovf       = 1'b0;
    placed    = 1'b0;
    hit       = 1'b0;
    case (phase)
      PH_FETCH: begin
        // every real block of the bucket moves into a free stash entry
        for (int z = 0; z < Z; z++) begin
          if (fetch_bkt[z][VB]) begin
            placed = 1'b0;
            for (int i = 0; i < STASH_N; i++) begin
              if (!placed && !ent_d[i][VB]) begin
                ent_d[i] = fetch_bkt[z];
                placed   = 1'b1;
              end
            end
            if (!placed) ovf = 1'b1;
          end
        end
      end
      PH_SERVE: begin
        for (int i = 0; i < STASH_N; i++) begin
          if (hit_vec[i]) begin
            hit            = 1'b1;
            rdata_d        = ent_q[i][DW-1:0];
            ent_d[i][LH:LL] = srv_leaf;
            if (srv_write) ent_d[i][DW-1:0] = srv_wdata;
          end
        end
        if (!hit) begin
          // first touch: the block appears holding zero (or the write data)
          rdata_d = '0;
          for (int i = 0; i < STASH_N; i++) begin
            if (!placed && !ent_d[i][VB]) begin
              ent_d[i] = {1'b1, srv_addr, srv_leaf,
                          (srv_write ? srv_wdata : {DW{1'b0}})};
              placed   = 1'b1;
            end
          end
          if (!placed) ovf = 1'b1;
        end
      end
      PH_EVICT: begin
        // greedy fill of this level; deeper levels were filled before
        for (int z = 0; z < Z; z++) begin
          placed = 1'b0;
          for (int i = 0; i < STASH_N; i++) begin
            if (!placed && ent_d[i][VB] &&
                same_branch(ent_d[i][LH:LL], path_leaf, int'(lvl))) begin
              evict_bkt[z]  = ent_d[i];
              ent_d[i][VB]  = 1'b0;
              placed        = 1'b1;
            end
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STASH_N; i++) ent_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      ent_q   <= ent_d;
      rdata_q <= rdata_d;
    end
  end

  assign srv_rdata = rdata_q;

  // A logical address is held by at most one stash entry when served (R5)
  p_unique_blk_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_SERVE) |-> $onehot0(hit_vec));

endmodule

// File: rtl/porm_ctrl.sv
module porm_ctrl
  import porm_pkg::*;
#(
  parameter int          L       = 3,
  parameter int          NBLK    = 8,
  parameter int          Z       = 4,
  parameter int          STASH_N = 16,
  parameter int          DW      = 16,
  parameter logic [15:0] SEED    = 16'hACE1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [$clog2(NBLK)-1:0]  req_addr,
  input  logic [DW-1:0]            req_wdata,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [DW-1:0]            rsp_rdata,
  output logic                     err
);

  localparam int AW   = $clog2(NBLK);
  localparam int NBKT = (2 ** (L + 1)) - 1;
  localparam int BW   = $clog2(NBKT);
  localparam int LVW  = $clog2(L + 1);
  localparam int SLW  = 1 + AW + L + DW;
  localparam int LAT  = 2 * L + 3;

  phase_e                ph;
  logic [LVW-1:0]        lvl;
  logic [L-1:0]          path_q, nleaf_q;
  logic [AW-1:0]         addr_q;
  logic                  wr_q;
  logic [DW-1:0]         wdata_q;
  logic [Z-1:0][SLW-1:0] tree_q [NBKT];
  logic [Z-1:0][SLW-1:0] fetch_bkt, evict_bkt;
  logic [BW-1:0]         bkt_idx;
  logic [2*L-1:0]        rnd;
  logic                  map_hit, ovf, accept;
  logic [L-1:0]          map_leaf;
  logic [7:0]            lat_cnt;

  assign req_ready = (ph == PH_IDLE);
  assign rsp_valid = (ph == PH_RESP);
  assign accept    = req_valid && req_ready;

  porm_lfsr #(.SEED(SEED), .OW(2 * L)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .step(accept), .rnd(rnd)
  );

  porm_posmap #(.NBLK(NBLK), .AW(AW), .L(L)) u_map (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(req_addr), .rd_hit(map_hit), .rd_leaf(map_leaf),
    .wr_en(ph == PH_SERVE), .wr_addr(addr_q), .wr_leaf(nleaf_q)
  );

  porm_stash #(.L(L), .AW(AW), .DW(DW), .Z(Z), .STASH_N(STASH_N),
               .LVW(LVW), .SLW(SLW)) u_stash (
    .clk(clk), .rst_n(rst_n), .phase(ph), .lvl(lvl), .path_leaf(path_q),
    .fetch_bkt(fetch_bkt), .evict_bkt(evict_bkt),
    .srv_addr(addr_q), .srv_write(wr_q), .srv_wdata(wdata_q),
    .srv_leaf(nleaf_q), .srv_rdata(rsp_rdata), .ovf(ovf)
  );

  // Heap index of the bucket at depth lvl on the path to path_q
  always_comb begin
    int lv;
    lv      = int'(lvl);
    bkt_idx = BW'((1 << lv) - 1 + int'(path_q >> (L - lv)));
  end

  assign fetch_bkt = tree_q[bkt_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph      <= PH_IDLE;
      lvl     <= '0;
      path_q  <= '0;
      nleaf_q <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      err     <= 1'b0;
      for (int b = 0; b < NBKT; b++) tree_q[b] <= '0;
    end else begin
      if (ovf) err <= 1'b1;
      case (ph)
        PH_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          path_q  <= map_hit ? map_leaf : rnd[L-1:0];
          nleaf_q <= rnd[2*L-1:L];
          lvl     <= '0;
          ph      <= PH_FETCH;
        end
        PH_FETCH: begin
          if (lvl == LVW'(L)) ph <= PH_SERVE;
          else                lvl <= lvl + LVW'(1);
        end
        PH_SERVE: begin
          lvl <= LVW'(L);
          ph  <= PH_EVICT;
        end
        PH_EVICT: begin
          tree_q[bkt_idx] <= evict_bkt;
          if (lvl == '0) ph <= PH_RESP;
          else           lvl <= lvl - LVW'(1);
        end
        PH_RESP: if (rsp_ready) ph <= PH_IDLE;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Cycle counter used only by the latency property below
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             lat_cnt <= '0;
    else if (accept)                        lat_cnt <= '0;
    else if (ph != PH_IDLE && ph != PH_RESP) lat_cnt <= lat_cnt + 8'd1;
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  p_lat_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> (lat_cnt == 8'(LAT)));

  p_rsp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

endmodule

// File: tb/test_porm_ctrl.sv
module test_porm_ctrl;

  localparam int L    = 3;
  localparam int LAT  = 2 * L + 3;
  localparam int NBLK = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;   // 4 ns period

  // default instance
  logic        b_valid = 1'b0, b_write = 1'b0, b_rsp_ready = 1'b0;
  logic [2:0]  b_addr = '0;
  logic [15:0] b_wdata = '0;
  logic        b_ready, b_rsp_valid, b_err;
  logic [15:0] b_rdata;

  // tiny instance used to provoke stash overflow
  logic        s_valid = 1'b0, s_write = 1'b0, s_rsp_ready = 1'b0;
  logic [2:0]  s_addr = '0;
  logic [15:0] s_wdata = '0;
  logic        s_ready, s_rsp_valid, s_err;
  logic [15:0] s_rdata;

  int n_chk = 0;
  int n_err = 0;
  int mem [NBLK];
  bit wrt [NBLK];

  porm_ctrl i_porm_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(b_valid), .req_ready(b_ready), .req_write(b_write),
    .req_addr(b_addr), .req_wdata(b_wdata),
    .rsp_valid(b_rsp_valid), .rsp_ready(b_rsp_ready), .rsp_rdata(b_rdata),
    .err(b_err)
  );

  porm_ctrl #(.L(1), .NBLK(8), .Z(1), .STASH_N(1), .DW(16)) i_porm_ctrl_small (
    .clk(clk), .rst_n(rst_n),
    .req_valid(s_valid), .req_ready(s_ready), .req_write(s_write),
    .req_addr(s_addr), .req_wdata(s_wdata),
    .rsp_valid(s_rsp_valid), .rsp_ready(s_rsp_ready), .rsp_rdata(s_rdata),
    .err(s_err)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // One access on the default instance, checked every cycle against the model
  task automatic acc(input bit wr, input int a, input int d, input int hold,
                     input bit keep);
    int expv;
    string tag;
    tag  = wr ? "R7" : (wrt[a] ? "R5" : "R6");
    expv = wrt[a] ? mem[a] : 0;
    if (wr) begin mem[a] = d; wrt[a] = 1'b1; end
    chk("R2 ready before request", b_ready, 1);
    b_valid = 1'b1; b_write = wr; b_addr = 3'(a); b_wdata = 16'(d);
    @(negedge clk);
    if (keep) begin
      // R2: request inputs change while busy and must be ignored
      b_write = 1'b1; b_addr = 3'd7; b_wdata = 16'hBEEF;
    end else begin
      b_valid = 1'b0;
    end
    for (int k = 0; k < LAT; k++) begin
      chk("R2 ready low while busy", b_ready, 0);
      chk("R3 no early response", b_rsp_valid, 0);
      chk("R9 no error", b_err, 0);
      @(negedge clk);
    end
    chk("R3 response due", b_rsp_valid, 1);
    chk(tag, b_rdata, 32'(expv));
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R4 held valid", b_rsp_valid, 1);
      chk("R4 held data", b_rdata, 32'(expv));
    end
    b_valid = 1'b0;
    b_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R4 consumed", b_rsp_valid, 0);
    chk("R4 ready again", b_ready, 1);
    b_rsp_ready = 1'b0;
  endtask

  task automatic sacc(input int a, input int d);
    s_valid = 1'b1; s_write = 1'b1; s_addr = 3'(a); s_wdata = 16'(d);
    @(negedge clk);
    s_valid = 1'b0;
    for (int k = 0; k < 50 && !s_rsp_valid; k++) @(negedge clk);
    s_rsp_ready = 1'b1;
    @(negedge clk);
    s_rsp_ready = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R3 watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NBLK; i++) begin mem[i] = 0; wrt[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk("R1 ready in reset", b_ready, 1);
    chk("R1 no response in reset", b_rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ready", b_ready, 1);
    chk("R1 no response", b_rsp_valid, 0);
    chk("R1 no error", b_err, 0);
    chk("R1 small no error", s_err, 0);

    acc(1'b0, 3, 0, 0, 1'b0);          // R6 unwritten read
    acc(1'b1, 3, 16'h1234, 0, 1'b0);   // R7 previous value 0
    acc(1'b0, 3, 0, 3, 1'b0);          // R5 with R4 back-pressure
    acc(1'b1, 3, 16'h5678, 1, 1'b0);   // R7 previous 1234
    for (int a = 0; a < NBLK; a++) acc(1'b1, a, a * 16'h0101 + 16'h20, a % 3, 1'b0);
    acc(1'b0, 5, 0, 0, 1'b1);          // R2 inputs wiggled while busy
    acc(1'b0, 7, 0, 0, 1'b0);          // R2 address 7 untouched by the wiggle
    for (int r = 0; r < 6; r++)
      for (int a = 0; a < NBLK; a++)
        acc(r[0], (a * 3 + r) % NBLK, r * 16'h111 + a, a % 2, 1'b0);

    sacc(0, 16'h11);
    chk("R8 no error after first block", s_err, 0);
    for (int a = 1; a < 5; a++) sacc(a, 16'h11 + a);
    chk("R8 overflow flagged", s_err, 1);
    sacc(6, 16'h66);
    chk("R8 flag sticky", s_err, 1);
    chk("R9 default instance clean", b_err, 0);

    finish_run();
  end

endmodule